// File: doc/BRIEF.md
# Display FIFO Fill Pacer

This block keeps count of the words sitting in a display FIFO and paces a DMA engine that fills it. It drives an active-low request while the FIFO holds fewer words than an almost-full level, so the DMA side stops short of the physical depth. It also shows empty and full flags. The full flag is only for debug. A sticky overflow flag records any write that arrived when no slot was free.

A display frame is a chain of DMA bursts. A frame starts on a frame reset pulse. At that moment the block clears its bookkeeping, samples the burst count and burst length, and loads the first readout control byte into its output latch. Each time a burst has been fully written into the FIFO, an interrupt pulse is raised and the next control byte is loaded in the same clock edge. The next burst then begins. After the last burst the block waits for the periodic frame tick. The tick comes from an internal clock divider and starts the next frame, which keeps the frame rate fixed.

Top module: `fifo_dma_pacer`

## Requirements
- R1: `dma_req_n` is low only while a frame is running and the occupancy is below `AFULL` (15 by default). It is high in the idle state, in the waiting state, and at occupancies of 15 or 16.
- R2: A write accepted on its own raises the occupancy by one. A read on its own lowers it by one. A write and a read in the same cycle leave it unchanged. A read while the FIFO is empty is ignored. Writes are counted in every state.
- R3: A write while the occupancy equals `DEPTH` (16) is dropped and sets `overflow`, which stays set until the next frame start. `fifo_full` is high exactly at occupancy 16, and it plays no part in the request.
- R4: `fifo_empty` is high exactly when the occupancy is zero.
- R5: A frame start clears the occupancy and `overflow`, loads `ctrl_data` into `ctrl_byte`, samples `cfg_bursts` and `cfg_words`, and enters the running state. A frame start comes from a `frame_rst` pulse, or from a `frame_tick` while waiting. The frame reset takes priority over a write or read in the same cycle.
- R6: A frame holds `cfg_bursts+1` bursts of `cfg_words+1` words each. A burst ends on the accepted write that completes its word count while running. A dropped write does not count.
- R7: When a burst other than the last one ends, `burst_irq` is high for the following cycle. In the same edge, `ctrl_byte` is loaded from `ctrl_data`. At any other time `ctrl_byte` holds its value.
- R8: After the last burst, the block waits with the request high. `frame_tick` then starts a new frame as in R5. A tick seen while idle or while running has no effect.
- R9: `frame_tick` is high for one cycle every `TICK_DIV` cycles. After a `frame_rst` edge, the first tick is high in the cycle that follows `TICK_DIV-1` further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rst | input | 1 | Frame reset pulse; starts a frame |
| cfg_bursts | input | CW | Bursts per frame minus one |
| cfg_words | input | CW | Words per burst minus one |
| ctrl_data | input | 8 | Next readout control byte |
| wr_en | input | 1 | DMA write into the FIFO |
| rd_en | input | 1 | Readout side takes a word |
| dma_req_n | output | 1 | Active-low DMA request |
| ctrl_byte | output | 8 | Latched readout control byte |
| burst_irq | output | 1 | Burst-complete interrupt pulse |
| frame_tick | output | 1 | Periodic frame tick |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | Debug: FIFO holds DEPTH words |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
The hardest state to reach is occupancy 16 with overflow set. The request is already released at 15, so a well-behaved DMA master never gets there. The bench ignores the request and keeps writing past the threshold, then drains the FIFO to see the request come back. The tick-driven frame start is also hard to reach, because it needs the waiting state to line up with the divider. The bench aligns the divider with a frame reset and counts cycles up to the tick edge. It then lets a second tick land in the running state to show that the tick is ignored there.

// File: rtl/fifo_dma_pacer.sv
module fifo_dma_pacer #(
  parameter int DEPTH    = 16,
  parameter int AFULL    = 15,
  parameter int CW       = 4,
  parameter int TICK_DIV = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_rst,
  input  logic [CW-1:0] cfg_bursts,
  input  logic [CW-1:0] cfg_words,
  input  logic [7:0]    ctrl_data,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          dma_req_n,
  output logic [7:0]    ctrl_byte,
  output logic          burst_irq,
  output logic          frame_tick,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          overflow
);
  localparam int OW = $clog2(DEPTH + 1);
  localparam int DW = $clog2(TICK_DIV);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} st_t;
  st_t st;

  logic [OW-1:0] occ;
  logic [CW-1:0] blft, wcnt, wlim;
  logic [DW-1:0] div;

  wire wr_ok = wr_en && (occ != OW'(DEPTH));
  wire rd_ok = rd_en && (occ != '0);
  wire start = frame_rst || (st == S_WAIT && frame_tick);

  assign frame_tick = (div == DW'(TICK_DIV - 1));
  assign dma_req_n  = !(st == S_RUN && occ < OW'(AFULL));
  assign fifo_empty = (occ == '0);
  assign fifo_full  = (occ == OW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      div <= '0;
    else if (frame_rst || frame_tick) div <= '0;
    else                             div <= div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                occ <= '0;
    else if (start)            occ <= '0;
    else if (wr_ok && !rd_ok)  occ <= occ + 1'b1;
    else if (rd_ok && !wr_ok)  occ <= occ - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                overflow <= 1'b0;
    else if (start)            overflow <= 1'b0;
    else if (wr_en && !wr_ok)  overflow <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      blft <= '0;
      wcnt <= '0;
      wlim <= '0;
      ctrl_byte <= '0;
      burst_irq <= 1'b0;
    end else if (start) begin
      st <= S_RUN;
      blft <= cfg_bursts;
      wlim <= cfg_words;
      wcnt <= '0;
      ctrl_byte <= ctrl_data;
      burst_irq <= 1'b0;
    end else begin
      burst_irq <= 1'b0;
      if (st == S_RUN && wr_ok) begin
        if (wcnt == wlim) begin
          wcnt <= '0;
          if (blft == '0) st <= S_WAIT;
          else begin
            blft <= blft - 1'b1;
            burst_irq <= 1'b1;
            ctrl_byte <= ctrl_data;
          end
        end else wcnt <= wcnt + 1'b1;
      end
    end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> (occ == $past(occ) || occ == $past(occ) + 1'b1 || occ + 1'b1 == $past(occ)));

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_en && fifo_full));

  assert_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_empty) |-> $past(wr_en));

  assert_start_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (fifo_empty && !overflow && !dma_req_n));

  assert_irq_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_irq |-> ctrl_byte == $past(ctrl_data));

  assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !frame_tick && !frame_rst) |=> (dma_req_n && $stable(ctrl_byte)));
endmodule

// File: tb/tb_fifo_dma_pacer.sv
module tb_fifo_dma_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 64;

  logic clk = 0, rst_n = 0, frame_rst = 0, wr_en = 0, rd_en = 0;
  logic [3:0] cfg_bursts = 0, cfg_words = 0;
  logic [7:0] ctrl_data = 0;
  logic dma_req_n, burst_irq, frame_tick, fifo_empty, fifo_full, overflow;
  logic [7:0] ctrl_byte;
  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_dma_pacer #(.DEPTH(16), .AFULL(15), .CW(4), .TICK_DIV(TDIV)) dut (
    .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst), .cfg_bursts(cfg_bursts),
    .cfg_words(cfg_words), .ctrl_data(ctrl_data), .wr_en(wr_en), .rd_en(rd_en),
    .dma_req_n(dma_req_n), .ctrl_byte(ctrl_byte), .burst_irq(burst_irq),
    .frame_tick(frame_tick), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .overflow(overflow));

  // {wr, rd, ctrl_data, exp req_n, exp empty, exp irq, exp ctrl_byte}
  localparam logic [20:0] VEC [0:9] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 8'hA0},
    {1'b1, 1'b0, 8'hA2, 1'b0, 1'b0, 1'b1, 8'hA2},
    {1'b0, 1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 8'hA2},
    {1'b1, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 8'hA2},
    {1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'hA6, 1'b1, 1'b0, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'hA7, 1'b1, 1'b1, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'hA8, 1'b1, 1'b1, 1'b0, 8'hA2},
    {1'b1, 1'b0, 8'hA9, 1'b1, 1'b0, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'hAA, 1'b1, 1'b1, 1'b0, 8'hA2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r);
    wr_en = w; rd_en = r;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic frst(input logic [3:0] b, input logic [3:0] w, input logic [7:0] cd);
    cfg_bursts = b; cfg_words = w; ctrl_data = cd; frame_rst = 1;
    @(negedge clk);
    frame_rst = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=below limit", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int req_seen;
    repeat (3) @(negedge clk);
    // reset state R1 R4 R3
    chk("R1 reset req_n", dma_req_n, 1);
    chk("R4 reset empty", fifo_empty, 1);
    chk("R3 reset full/ovf", {fifo_full, overflow}, 0);
    chk("R7 reset irq/ctrl", {burst_irq, ctrl_byte}, 0);
    rst_n = 1;
    // R8: ticks while idle are ignored
    ctrl_data = 8'h5A;
    req_seen = 0;
    for (int i = 0; i < TDIV + 6; i++) begin
      cyc(0, 0);
      if (!dma_req_n) req_seen++;
    end
    chk("R8 idle tick ignored req", req_seen, 0);
    chk("R8 idle tick ignored ctrl", ctrl_byte, 0);

    // R1 R3 R6 R7: throttle, full, overflow
    frst(4'd15, 4'd15, 8'h11);
    chk("R5 start ctrl", ctrl_byte, 8'h11);
    repeat (14) cyc(1, 0);
    chk("R1 req at 14", dma_req_n, 0);
    cyc(1, 0);
    chk("R1 req at 15", dma_req_n, 1);
    chk("R3 full at 15", fifo_full, 0);
    ctrl_data = 8'h22;
    cyc(1, 0);
    chk("R3 full at 16", fifo_full, 1);
    chk("R6 16-word burst irq", burst_irq, 1);
    chk("R7 ctrl load on irq", ctrl_byte, 8'h22);
    ctrl_data = 8'h23;
    cyc(1, 0);
    chk("R3 overflow set", overflow, 1);
    chk("R3 still full", fifo_full, 1);
    chk("R7 irq one cycle", burst_irq, 0);
    chk("R7 ctrl hold", ctrl_byte, 8'h22);
    cyc(0, 1);
    chk("R3 full drop after read", fifo_full, 0);
    chk("R3 overflow sticky", overflow, 1);
    chk("R1 req high at 15", dma_req_n, 1);
    cyc(0, 1);
    chk("R1 req back at 14", dma_req_n, 0);

    // R5: frame reset clears bookkeeping, dominates a write
    wr_en = 1;
    frst(4'd2, 4'd0, 8'h33);
    wr_en = 0;
    chk("R5 empty after reset", fifo_empty, 1);
    chk("R5 overflow cleared", overflow, 0);
    chk("R5 req running", dma_req_n, 0);
    chk("R5 ctrl loaded", ctrl_byte, 8'h33);
    ctrl_data = 8'h34;
    cyc(1, 0);
    chk("R6 one-word burst irq", burst_irq, 1);
    chk("R7 ctrl next", ctrl_byte, 8'h34);
    cyc(1, 0);
    chk("R6 second burst irq", burst_irq, 1);
    cyc(1, 0);
    chk("R6 last burst no irq", burst_irq, 0);
    chk("R8 waiting req_n", dma_req_n, 1);

    // R9 R8: tick alignment and tick-started frame
    frst(4'd0, 4'd0, 8'hC0);
    cyc(1, 0);
    chk("R8 single burst wait", dma_req_n, 1);
    ctrl_data = 8'hD5; cfg_bursts = 4'd0; cfg_words = 4'd3;
    repeat (TDIV - 3) cyc(0, 0);
    chk("R9 no tick early", frame_tick, 0);
    cyc(0, 0);
    chk("R9 tick on time", frame_tick, 1);
    chk("R8 ctrl held while waiting", ctrl_byte, 8'hC0);
    cyc(0, 0);
    chk("R9 tick one cycle", frame_tick, 0);
    chk("R8 tick starts frame ctrl", ctrl_byte, 8'hD5);
    chk("R8 tick starts frame req", dma_req_n, 0);
    chk("R5 tick clears occupancy", fifo_empty, 1);

    // R8: tick ignored while running; R6 sampled length
    ctrl_data = 8'hE7;
    repeat (TDIV - 1) cyc(0, 0);
    chk("R9 second tick", frame_tick, 1);
    cyc(0, 0);
    chk("R8 run tick ignored ctrl", ctrl_byte, 8'hD5);
    chk("R8 run tick ignored req", dma_req_n, 0);
    repeat (3) cyc(1, 0);
    chk("R6 sampled words not done", dma_req_n, 0);
    cyc(1, 0);
    chk("R6 sampled words done", dma_req_n, 1);

    // table walk: R1 R2 R4 R6 R7
    frst(4'd1, 4'd1, 8'hA0);
    for (int i = 0; i < 10; i++) begin
      ctrl_data = VEC[i][18:11];
      cyc(VEC[i][20], VEC[i][19]);
      chk($sformatf("R1/R2/R4/R7 vector %0d", i),
          {dma_req_n, fifo_empty, burst_irq, ctrl_byte}, VEC[i][10:0]);
    end

    // R2: write and read together when empty
    cyc(1, 1);
    chk("R2 wr+rd at empty", fifo_empty, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule